// File: doc/BRIEF.md
# Translation Context Control and Fault Register Bank

This block is the register file that sits beside an I/O address translation unit. It holds the per-context settings that the translation datapath needs: an enable and control word, two table base pairs, a translation control word, a bus control word and two memory attribute words. It also records faults that the datapath reports and turns them into a level interrupt. A host reaches every context through one flat 32-bit register window, one 64-byte slice per context.

Fault reporting works on a capture-first rule. The first fault seen by an idle context records its flags, error code, walk level and faulting address. Later faults add their flag bits but keep the first record. Software reads the address and then writes zero to the status word to clear everything. After that the address word reads zero. The block asks the TLB for an invalidation with a one-cycle request per context. The control word's flush bit stays set until the TLB acknowledges, so software can poll it.

Top module: `iommu_ctx_bank`

## Requirements
- R1: After reset every register of every context reads 0, `irq` is 0 and `flush_req` is all zero.
- R2: Context n's registers sit at byte address n*0x40 plus the offset: control 0x00, status 0x20, fault address 0x24. Eight plain storage words sit at 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x28 and 0x2C and read back what was written. Any other offset reads 0 and ignores writes. A read returns its data with `host_rvalid` one cycle after `host_rd`.
- R3: In the control word only bits 0 (enable), 1 (flush), 2 (interrupt enable), 3, 5:4, 16 and 17 are writable. All other bits read 0.
- R4: Writing control with bit 1 set makes bit 1 read 1 and pulses `flush_req[n]` for exactly one cycle, visible in the cycle after the write. A further flush write while the flush is pending and not being acknowledged does not pulse again.
- R5: A one-cycle `flush_ack[n]` returns control bit 1 to 0. An acknowledge with no flush pending changes nothing.
- R6: A fault with at least one flag set is captured into an idle context. The status word holds translation fault in bit 0, page fault in bit 1, walk abort in bit 2, multiple hit in bit 4, the error code in bits 10:8 and the level in bits 13:12. The faulting address is also captured. `flt_flags` maps bit 0 to translation fault, bit 1 to page fault, bit 2 to walk abort and bit 3 to multiple hit. A fault with no flag bits is ignored.
- R7: A fault that arrives while flags are already set ORs in its flags and leaves the code, level and address unchanged.
- R8: Writing 0 to status clears flags, code, level and address. Writing a nonzero value to status is ignored. A fault in the same cycle as the clearing write is captured as a fresh first fault.
- R9: The fault address word reads 0 whenever the context's flags are all clear.
- R10: `irq` is a registered level. It is 1 one cycle after any context has interrupt enable set and a flag set, and it drops one cycle after that stops being true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | ADDR_W | Byte address of the register |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| flt_valid | input | 1 | Fault report strobe from the datapath |
| flt_ctx | input | CTX_W | Context of the fault |
| flt_flags | input | 4 | Fault flags: mhit, abort, page, translation (MSB to LSB) |
| flt_code | input | 3 | Error code |
| flt_lvl | input | 2 | Table level of the error |
| flt_addr | input | 32 | Faulting input address |
| flush_req | output | NCTX | One-cycle TLB invalidation request per context |
| flush_ack | input | NCTX | One-cycle invalidation done per context |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with four contexts and an 8-bit address. This puts the top window at 0xC0 within reach, so decode of every context index can be observed, together with isolation between neighbours. With this size, one context can hold a fault while another has interrupts masked. The bench exercises the race between the status clear and a new fault, and the race between a flush write and its acknowledge.

// File: rtl/iommu_ctx_pkg.sv
package iommu_ctx_pkg;
  localparam int DW          = 32;
  localparam int SPAN_LG     = 6;
  localparam int NPLAIN      = 8;
  localparam int PLAIN_W     = $clog2(NPLAIN);
  localparam int NFLAG       = 4;

  localparam logic [5:0] OFS_CTL   = 6'h00;
  localparam logic [5:0] OFS_STAT  = 6'h20;
  localparam logic [5:0] OFS_FADDR = 6'h24;

  localparam int FLUSH_BIT = 1;
  localparam int INTEN_BIT = 2;
  localparam logic [DW-1:0] CTL_WMASK = 32'h0003_003D;

  typedef enum logic [2:0] {SEL_NONE, SEL_CTL, SEL_STAT, SEL_FADDR, SEL_PLAIN} sel_e;

  function automatic logic [DW-1:0] stat_pack(input logic [NFLAG-1:0] flags,
                                               input logic [2:0] code,
                                               input logic [1:0] lvl);
    return {18'b0, lvl, 1'b0, code, 3'b0, flags[3], 1'b0, flags[2:0]};
  endfunction

  function automatic logic [PLAIN_W-1:0] plain_slot(input logic [5:0] ofs);
    case (ofs)
      6'h08:   return 3'd0;
      6'h0C:   return 3'd1;
      6'h10:   return 3'd2;
      6'h14:   return 3'd3;
      6'h18:   return 3'd4;
      6'h1C:   return 3'd5;
      6'h28:   return 3'd6;
      default: return 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/ctx_decode.sv
module ctx_decode
  import iommu_ctx_pkg::*;
#(
  parameter int NCTX   = 4,
  parameter int CTX_W  = $clog2(NCTX),
  parameter int ADDR_W = SPAN_LG + CTX_W
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [CTX_W-1:0]   ctx_idx,
  output sel_e               sel,
  output logic [PLAIN_W-1:0] plain_idx
);
  logic [5:0] ofs;

  always_comb begin
    ofs       = {addr[5:2], 2'b00};
    ctx_idx   = addr[ADDR_W-1:SPAN_LG];
    plain_idx = plain_slot(ofs);
    case (ofs)
      OFS_CTL:   sel = SEL_CTL;
      OFS_STAT:  sel = SEL_STAT;
      OFS_FADDR: sel = SEL_FADDR;
      6'h08, 6'h0C, 6'h10, 6'h14,
      6'h18, 6'h1C, 6'h28, 6'h2C: sel = SEL_PLAIN;
      default:   sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/ctx_slot.sv
module ctx_slot
  import iommu_ctx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  sel_e               sel,
  input  logic [PLAIN_W-1:0] plain_idx,
  input  logic [DW-1:0]      wdata,
  input  logic               flt_hit,
  input  logic [NFLAG-1:0]   flt_flags,
  input  logic [2:0]         flt_code,
  input  logic [1:0]         flt_lvl,
  input  logic [DW-1:0]      flt_addr,
  input  logic               flush_ack,
  output logic               flush_req,
  output logic               irq_src,
  output logic [DW-1:0]      rd_word
);
  logic [DW-1:0]    ctl_q;
  logic             pend_q;
  logic [NFLAG-1:0] flags_q;
  logic [2:0]       code_q;
  logic [1:0]       lvl_q;
  logic [DW-1:0]    faddr_q;
  logic [DW-1:0]    plain_q [NPLAIN];

  logic wr_ctl, wr_flush, stat_clr, flt_new, idle_ctx;

  always_comb begin
    wr_ctl   = wr_en && (sel == SEL_CTL);
    wr_flush = wr_ctl && wdata[FLUSH_BIT];
    stat_clr = wr_en && (sel == SEL_STAT) && (wdata == '0);
    flt_new  = flt_hit && (|flt_flags);
    idle_ctx = (flags_q == '0) || stat_clr;
  end

  // control word and flush handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      pend_q    <= 1'b0;
      flush_req <= 1'b0;
    end else begin
      if (wr_ctl) ctl_q <= wdata & CTL_WMASK & ~(32'd1 << FLUSH_BIT);
      pend_q    <= wr_flush | (pend_q & ~flush_ack);
      flush_req <= wr_flush & (~pend_q | flush_ack);
    end
  end

  // fault capture
  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      code_q  <= '0;
      lvl_q   <= '0;
      faddr_q <= '0;
    end else begin
      if (stat_clr) begin
        flags_q <= '0;
        code_q  <= '0;
        lvl_q   <= '0;
        faddr_q <= '0;
      end
      if (flt_new) begin
        if (idle_ctx) begin
          flags_q <= flt_flags;
          code_q  <= flt_code;
          lvl_q   <= flt_lvl;
          faddr_q <= flt_addr;
        end else begin
          flags_q <= flags_q | flt_flags;
        end
      end
    end
  end

  // plain storage words
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPLAIN; i++) plain_q[i] <= '0;
    end else if (wr_en && (sel == SEL_PLAIN)) begin
      plain_q[plain_idx] <= wdata;
    end
  end

  always_comb begin
    irq_src = ctl_q[INTEN_BIT] && (flags_q != '0);
    case (sel)
      SEL_CTL:   rd_word = ctl_q | (DW'(pend_q) << FLUSH_BIT);
      SEL_STAT:  rd_word = stat_pack(flags_q, code_q, lvl_q);
      SEL_FADDR: rd_word = faddr_q;
      SEL_PLAIN: rd_word = plain_q[plain_idx];
      default:   rd_word = '0;
    endcase
  end

  // R4
  req_has_pend_chk: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> pend_q);
  // R5
  ack_drops_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && flush_ack && !wr_flush) |=> !pend_q);
  // R7
  first_addr_kept_chk: assert property (@(posedge clk) disable iff (rst)
    ((flags_q != '0) && !stat_clr) |=> $stable(faddr_q));
  // R8
  zero_write_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !flt_new) |=> (flags_q == '0));
  // R9
  addr_zero_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (flags_q == '0) |-> (faddr_q == '0));
endmodule

// File: rtl/iommu_ctx_bank.sv
module iommu_ctx_bank
  import iommu_ctx_pkg::*;
#(
  parameter int NCTX   = 4,
  parameter int CTX_W  = $clog2(NCTX),
  parameter int ADDR_W = SPAN_LG + CTX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_rvalid,
  input  logic              flt_valid,
  input  logic [CTX_W-1:0]  flt_ctx,
  input  logic [3:0]        flt_flags,
  input  logic [2:0]        flt_code,
  input  logic [1:0]        flt_lvl,
  input  logic [31:0]       flt_addr,
  output logic [NCTX-1:0]   flush_req,
  input  logic [NCTX-1:0]   flush_ack,
  output logic              irq
);
  logic [CTX_W-1:0]   dec_ctx;
  sel_e               dec_sel;
  logic [PLAIN_W-1:0] dec_plain;
  logic [DW-1:0]      slot_rd [NCTX];
  logic [NCTX-1:0]    slot_irq;

  ctx_decode #(.NCTX(NCTX), .CTX_W(CTX_W), .ADDR_W(ADDR_W)) u_dec (
    .addr(host_addr), .ctx_idx(dec_ctx), .sel(dec_sel), .plain_idx(dec_plain)
  );

  for (genvar g = 0; g < NCTX; g++) begin : g_ctx
    ctx_slot u_slot (
      .clk(clk), .rst(rst),
      .wr_en(host_wr && (dec_ctx == CTX_W'(g))),
      .sel(dec_sel), .plain_idx(dec_plain), .wdata(host_wdata),
      .flt_hit(flt_valid && (flt_ctx == CTX_W'(g))),
      .flt_flags(flt_flags), .flt_code(flt_code), .flt_lvl(flt_lvl),
      .flt_addr(flt_addr),
      .flush_ack(flush_ack[g]), .flush_req(flush_req[g]),
      .irq_src(slot_irq[g]), .rd_word(slot_rd[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
      irq         <= 1'b0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) host_rdata <= slot_rd[dec_ctx];
      irq <= |slot_irq;
    end
  end

  // R2
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> host_rvalid);
  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_irq == '0) |=> !irq);
endmodule

// File: tb/iommu_ctx_bank_test.sv
module iommu_ctx_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCTX = 4;
  localparam int CTX_W = 2;
  localparam int ADDR_W = 8;

  logic clk = 0, rst = 1;
  logic host_wr = 0, host_rd = 0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic host_rvalid;
  logic flt_valid = 0;
  logic [CTX_W-1:0] flt_ctx = '0;
  logic [3:0] flt_flags = '0;
  logic [2:0] flt_code = '0;
  logic [1:0] flt_lvl = '0;
  logic [31:0] flt_addr = '0;
  logic [NCTX-1:0] flush_req, flush_ack = '0;
  logic irq;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  iommu_ctx_bank #(.NCTX(NCTX)) uut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .flt_valid(flt_valid), .flt_ctx(flt_ctx),
    .flt_flags(flt_flags), .flt_code(flt_code), .flt_lvl(flt_lvl),
    .flt_addr(flt_addr), .flush_req(flush_req), .flush_ack(flush_ack), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && host_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected rvalid", 32'd1, 32'd0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, host_rdata, e);
      end
    end
  end

  task automatic wr(int c, logic [5:0] ofs, logic [31:0] d);
    @(negedge clk);
    host_wr = 1; host_addr = ADDR_W'(c * 64 + ofs); host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd(int c, logic [5:0] ofs, logic [31:0] e, string t);
    @(negedge clk);
    host_rd = 1; host_addr = ADDR_W'(c * 64 + ofs);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic fault(int c, logic [3:0] f, logic [2:0] code, logic [1:0] lv,
                       logic [31:0] a);
    @(negedge clk);
    flt_valid = 1; flt_ctx = CTX_W'(c); flt_flags = f; flt_code = code;
    flt_lvl = lv; flt_addr = a;
    @(negedge clk);
    flt_valid = 0;
  endtask

  task automatic ack(int c);
    @(negedge clk);
    flush_ack = NCTX'(1) << c;
    @(negedge clk);
    flush_ack = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 irq after reset", 32'(irq), 0);
    check("R1 flush_req after reset", 32'(flush_req), 0);
    for (int c = 0; c < NCTX; c++) begin
      rd(c, 6'h00, 0, "R1 ctl reset");
      rd(c, 6'h20, 0, "R1 stat reset");
      rd(c, 6'h10, 0, "R1 plain reset");
    end
    // R2 address map and isolation
    wr(2, 6'h10, 32'hA5A5_0001);
    wr(2, 6'h2C, 32'h0BAD_F00D);
    wr(3, 6'h08, 32'h1357_9BDF);
    wr(2, 6'h30, 32'hFFFF_FFFF);
    rd(2, 6'h10, 32'hA5A5_0001, "R2 plain 0x10");
    rd(2, 6'h2C, 32'h0BAD_F00D, "R2 plain 0x2C");
    rd(3, 6'h08, 32'h1357_9BDF, "R2 top context");
    rd(1, 6'h10, 0, "R2 neighbour isolation");
    rd(2, 6'h30, 0, "R2 unmapped offset");
    // R3 control mask
    wr(0, 6'h00, 32'hFFFF_FFFD);
    rd(0, 6'h00, 32'h0003_003D, "R3 ctl mask");
    // R4 flush request
    wr(1, 6'h00, 32'h0000_0002);
    check("R4 flush pulse", 32'(flush_req), 32'h2);
    idle(1);
    check("R4 flush pulse width", 32'(flush_req), 0);
    rd(1, 6'h00, 32'h2, "R4 flush bit pending");
    wr(1, 6'h00, 32'h0000_0002);
    check("R4 no repulse while pending", 32'(flush_req), 0);
    // R5 acknowledge
    ack(1);
    rd(1, 6'h00, 0, "R5 ack clears flush");
    ack(2);
    check("R5 stray ack no pulse", 32'(flush_req), 0);
    rd(2, 6'h00, 0, "R5 stray ack no effect");
    // R6 capture
    wr(3, 6'h00, 32'h5);
    fault(3, 4'b0000, 3'd5, 2'd2, 32'h9999_0000);
    rd(3, 6'h20, 0, "R6 empty fault ignored");
    fault(3, 4'b0010, 3'd4, 2'd1, 32'h1234_5670);
    idle(1);
    check("R10 irq raised", 32'(irq), 1);
    rd(3, 6'h20, 32'h0000_1402, "R6 status layout");
    rd(3, 6'h24, 32'h1234_5670, "R6 address captured");
    // R7 later fault
    fault(3, 4'b1000, 3'd1, 2'd3, 32'hDEAD_0000);
    rd(3, 6'h20, 32'h0000_1412, "R7 flags ORed code kept");
    rd(3, 6'h24, 32'h1234_5670, "R7 first address kept");
    // R8 clear rules
    wr(3, 6'h20, 32'h0000_00FF);
    rd(3, 6'h20, 32'h0000_1412, "R8 nonzero write ignored");
    wr(3, 6'h20, 32'h0);
    idle(1);
    check("R10 irq dropped", 32'(irq), 0);
    rd(3, 6'h20, 0, "R8 zero write clears");
    rd(3, 6'h24, 0, "R9 address zero after clear");
    // R10 masked context
    fault(2, 4'b0001, 3'd1, 2'd0, 32'h0000_4000);
    idle(1);
    check("R10 masked no irq", 32'(irq), 0);
    rd(2, 6'h20, 32'h0000_0101, "R6 translation fault ctx2");
    // R8 clear and fault race
    @(negedge clk);
    host_wr = 1; host_addr = ADDR_W'(2 * 64 + 32); host_wdata = 0;
    flt_valid = 1; flt_ctx = 2'd2; flt_flags = 4'b0100; flt_code = 3'd5;
    flt_lvl = 2'd2; flt_addr = 32'h0000_8888;
    @(negedge clk);
    host_wr = 0; flt_valid = 0;
    rd(2, 6'h20, 32'h0000_2504, "R8 fault wins over clear");
    rd(2, 6'h24, 32'h0000_8888, "R8 fresh address");
    idle(3);
    if (exp_q.size() != 0) check("R2 reads outstanding", 32'(exp_q.size()), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule